// File: doc/BRIEF.md
# Trap Return State Restorer

This block carries out the two ways of leaving a trap handler. One variant resumes at the instruction after the trapped one. The other runs the trapped instruction again. A request lasts one cycle. It arrives with a function code, the two privilege bits, the current trap level, and the saved words for that level: the packed saved-state word, the saved PC and the saved next-PC.

The block first decides whether the request may proceed. If it may, it splits the saved-state word into the window pointer, the processor-state field and the address-space identifier. It picks the new PC and next-PC and lowers the trap level by one. All of these results are written to output registers on a single clock edge. A refused request leaves every register as it was and reports only a fault code. Whoever owns the trap stack and the fetch unit reads the outputs one cycle after the request.

Top module: `trap_return_unit`

## Requirements
- R1: While `rst` is high, every output register is cleared at each clock edge: `res_valid` is 0, `res_fault` is 0, and the window pointer, processor state, identifier, PC, next-PC and trap level outputs are all 0.
- R2: `res_valid` is 1 in exactly the cycle after a cycle with `req_valid` high, and 0 in every other cycle.
- R3: On an accepted request, `out_cwp` takes saved-state bits 4:0, `out_pstate` takes bits 20:8 and `out_asi` takes bits 31:24.
- R4: An accepted request with `req_fn` = 0 (resume after) sets `out_pc` to the saved next-PC and `out_npc` to the saved next-PC plus 4, modulo 2^PC_W.
- R5: An accepted request with `req_fn` = 1 (re-execute) sets `out_pc` to the saved PC and `out_npc` to the saved next-PC.
- R6: An accepted request sets `out_tl` to the input trap level minus one.
- R7: A request with a valid function code and at least one privilege bit set, but with trap level 0, reports `res_fault` = 1 (illegal instruction) and changes no state output.
- R8: A request with a valid function code and both `priv_state` and `priv_hyper` low reports `res_fault` = 2 (privileged action) and changes no state output. This holds even when the trap level is 0.
- R9: A `req_fn` value other than 0 or 1 reports `res_fault` = 1 whatever the privilege bits and trap level are, and changes no state output.
- R10: Either privilege bit on its own is enough for a request to be accepted.
- R11: An accepted request reports `res_fault` = 0 and updates all state outputs on the same edge. When no request is present, the state outputs hold their values, whatever appears on the saved-word inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle trap-return request |
| req_fn | input | FCN_W | Function code: 0 resumes after the trapped instruction, 1 re-executes it |
| priv_state | input | 1 | Privilege bit of the processor-state register |
| priv_hyper | input | 1 | Privilege bit of the hypervisor-state register |
| cur_tl | input | TL_W | Current trap level |
| saved_state | input | TS_W | Packed saved-state word for the current level |
| saved_pc | input | PC_W | Saved PC for the current level |
| saved_npc | input | PC_W | Saved next-PC for the current level |
| res_valid | output | 1 | Result strobe, one cycle after a request |
| res_fault | output | 2 | 0 none, 1 illegal instruction, 2 privileged action |
| out_cwp | output | 5 | Restored window pointer |
| out_pstate | output | 13 | Restored processor-state field |
| out_asi | output | 8 | Restored address-space identifier |
| out_pc | output | PC_W | New PC |
| out_npc | output | PC_W | New next-PC |
| out_tl | output | TL_W | New trap level |

## Verification
Some properties are checked on every cycle. These are the one-cycle result strobe, the rule that state holds when no request is present and when a request is refused, the trap-level decrement, the re-execute PC choice, and the privileged-action code when neither privilege bit is set. The bench scenarios are needed for the rest. They cover the exact bit fields taken from the saved-state word and the wrap of next-PC plus 4 at the top of the address space. They also show the ordering among the three fault causes when several are present at once, and back-to-back requests with differing function codes.

// File: rtl/trp_pkg.sv
package trp_pkg;
  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_ILLEGAL = 2'd1,
    FLT_PRIV    = 2'd2
  } fault_e;

  // bit positions inside the packed saved-state word
  localparam int CWP_LO = 0;
  localparam int CWP_HI = 4;
  localparam int PST_LO = 8;
  localparam int PST_HI = 20;
  localparam int ASI_LO = 24;
  localparam int ASI_HI = 31;
  localparam int CWP_W  = CWP_HI - CWP_LO + 1;
  localparam int PST_W  = PST_HI - PST_LO + 1;
  localparam int ASI_W  = ASI_HI - ASI_LO + 1;
  localparam int TS_MIN = ASI_HI + 1;

  localparam int FN_RESUME = 0;
  localparam int FN_REDO   = 1;
endpackage

// File: rtl/trp_fault_check.sv
module trp_fault_check
  import trp_pkg::*;
#(
  parameter int TL_W  = 3,
  parameter int FCN_W = 5
) (
  input  logic [FCN_W-1:0] fn,
  input  logic             priv_state,
  input  logic             priv_hyper,
  input  logic [TL_W-1:0]  tl,
  output fault_e           fault,
  output logic             is_redo
);
  localparam logic [FCN_W-1:0] FN_A = FCN_W'(FN_RESUME);
  localparam logic [FCN_W-1:0] FN_B = FCN_W'(FN_REDO);

  logic fn_ok;

  always_comb begin
    fn_ok   = (fn == FN_A) || (fn == FN_B);
    is_redo = (fn == FN_B);
    // decode first, then privilege, then trap level
    if (!fn_ok)
      fault = FLT_ILLEGAL;
    else if (!(priv_state || priv_hyper))
      fault = FLT_PRIV;
    else if (tl == '0)
      fault = FLT_ILLEGAL;
    else
      fault = FLT_NONE;
  end
endmodule

// File: rtl/trp_state_unpack.sv
module trp_state_unpack
  import trp_pkg::*;
#(
  parameter int TS_W = 32
) (
  input  logic [TS_W-1:0]  tstate,
  output logic [CWP_W-1:0] cwp,
  output logic [PST_W-1:0] pstate,
  output logic [ASI_W-1:0] asi
);
  assign cwp    = tstate[CWP_HI:CWP_LO];
  assign pstate = tstate[PST_HI:PST_LO];
  assign asi    = tstate[ASI_HI:ASI_LO];

  logic unused_gap;
  generate
    if (TS_W > TS_MIN) begin : g_wide
      assign unused_gap = ^{tstate[TS_W-1:TS_MIN], tstate[ASI_LO-1:PST_HI+1],
                            tstate[PST_LO-1:CWP_HI+1]};
    end else begin : g_exact
      assign unused_gap = ^{tstate[ASI_LO-1:PST_HI+1], tstate[PST_LO-1:CWP_HI+1]};
    end
  endgenerate

  initial begin
    assert_ts_width_R3 : assert (TS_W >= TS_MIN)
      else $error("saved-state word narrower than field layout");
  end
endmodule

// File: rtl/trp_pc_select.sv
module trp_pc_select #(
  parameter int PC_W = 64
) (
  input  logic            is_redo,
  input  logic [PC_W-1:0] tpc,
  input  logic [PC_W-1:0] tnpc,
  output logic [PC_W-1:0] pc_n,
  output logic [PC_W-1:0] npc_n
);
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  always_comb begin
    if (is_redo) begin
      pc_n  = tpc;
      npc_n = tnpc;
    end else begin
      pc_n  = tnpc;
      npc_n = tnpc + STEP;
    end
  end
endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
  import trp_pkg::*;
#(
  parameter int PC_W  = 64,
  parameter int TL_W  = 3,
  parameter int TS_W  = 32,
  parameter int FCN_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [FCN_W-1:0]  req_fn,
  input  logic              priv_state,
  input  logic              priv_hyper,
  input  logic [TL_W-1:0]   cur_tl,
  input  logic [TS_W-1:0]   saved_state,
  input  logic [PC_W-1:0]   saved_pc,
  input  logic [PC_W-1:0]   saved_npc,
  output logic              res_valid,
  output logic [1:0]        res_fault,
  output logic [4:0]        out_cwp,
  output logic [12:0]       out_pstate,
  output logic [7:0]        out_asi,
  output logic [PC_W-1:0]   out_pc,
  output logic [PC_W-1:0]   out_npc,
  output logic [TL_W-1:0]   out_tl
);
  localparam logic [TL_W-1:0] TL_ONE = TL_W'(1);

  fault_e           fault_c;
  logic             redo_c;
  logic [CWP_W-1:0] cwp_c;
  logic [PST_W-1:0] pst_c;
  logic [ASI_W-1:0] asi_c;
  logic [PC_W-1:0]  pc_c;
  logic [PC_W-1:0]  npc_c;
  logic             commit;

  trp_fault_check #(.TL_W(TL_W), .FCN_W(FCN_W)) u_check (
    .fn(req_fn), .priv_state(priv_state), .priv_hyper(priv_hyper),
    .tl(cur_tl), .fault(fault_c), .is_redo(redo_c)
  );

  trp_state_unpack #(.TS_W(TS_W)) u_unpack (
    .tstate(saved_state), .cwp(cwp_c), .pstate(pst_c), .asi(asi_c)
  );

  trp_pc_select #(.PC_W(PC_W)) u_pcsel (
    .is_redo(redo_c), .tpc(saved_pc), .tnpc(saved_npc),
    .pc_n(pc_c), .npc_n(npc_c)
  );

  assign commit = req_valid && (fault_c == FLT_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_fault  <= FLT_NONE;
      out_cwp    <= '0;
      out_pstate <= '0;
      out_asi    <= '0;
      out_pc     <= '0;
      out_npc    <= '0;
      out_tl     <= '0;
    end else begin
      res_valid <= req_valid;
      res_fault <= req_valid ? fault_c : FLT_NONE;
      if (commit) begin
        out_cwp    <= cwp_c;
        out_pstate <= pst_c;
        out_asi    <= asi_c;
        out_pc     <= pc_c;
        out_npc    <= npc_c;
        out_tl     <= cur_tl - TL_ONE;
      end
    end
  end

  // result strobe follows the request by exactly one cycle
  assert_strobe_R2 : assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid);
  assert_no_strobe_R2 : assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_valid);

  // no request: architectural state holds
  assert_idle_hold_R11 : assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable({out_cwp, out_pstate, out_asi, out_pc, out_npc, out_tl}));

  // refused request: architectural state holds (R7, R8, R9)
  assert_fault_hold_R7 : assert property (@(posedge clk) disable iff (rst)
    (req_valid && fault_c != FLT_NONE) |=>
      $stable({out_cwp, out_pstate, out_asi, out_pc, out_npc, out_tl}));

  assert_tl_dec_R6 : assert property (@(posedge clk) disable iff (rst)
    commit |=> (out_tl == $past(cur_tl) - TL_ONE));

  assert_redo_pc_R5 : assert property (@(posedge clk) disable iff (rst)
    (commit && req_fn == FCN_W'(FN_REDO)) |=>
      (out_pc == $past(saved_pc) && out_npc == $past(saved_npc)));

  assert_priv_code_R8 : assert property (@(posedge clk) disable iff (rst)
    (req_valid && !priv_state && !priv_hyper &&
     (req_fn == FCN_W'(FN_RESUME) || req_fn == FCN_W'(FN_REDO))) |=>
      (res_fault == FLT_PRIV));
endmodule

// File: tb/trap_return_unit_test.sv
`timescale 1ns/1ps
module trap_return_unit_test;
  import trp_pkg::*;

  localparam int PC_W = 64, TL_W = 3, TS_W = 32, FCN_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [FCN_W-1:0] req_fn = '0;
  logic priv_state = 1'b0, priv_hyper = 1'b0;
  logic [TL_W-1:0] cur_tl = '0;
  logic [TS_W-1:0] saved_state = '0;
  logic [PC_W-1:0] saved_pc = '0, saved_npc = '0;
  logic res_valid;
  logic [1:0] res_fault;
  logic [4:0] out_cwp;
  logic [12:0] out_pstate;
  logic [7:0] out_asi;
  logic [PC_W-1:0] out_pc, out_npc;
  logic [TL_W-1:0] out_tl;

  always #2.5 clk = ~clk;

  trap_return_unit #(.PC_W(PC_W), .TL_W(TL_W), .TS_W(TS_W), .FCN_W(FCN_W)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_fn(req_fn),
    .priv_state(priv_state), .priv_hyper(priv_hyper), .cur_tl(cur_tl),
    .saved_state(saved_state), .saved_pc(saved_pc), .saved_npc(saved_npc),
    .res_valid(res_valid), .res_fault(res_fault), .out_cwp(out_cwp),
    .out_pstate(out_pstate), .out_asi(out_asi), .out_pc(out_pc),
    .out_npc(out_npc), .out_tl(out_tl)
  );

  typedef struct packed {
    logic [1:0]      flt;
    logic [4:0]      cwp;
    logic [12:0]     pst;
    logic [7:0]      asi;
    logic [PC_W-1:0] pc;
    logic [PC_W-1:0] npc;
    logic [TL_W-1:0] tl;
  } exp_t;

  exp_t  exp_q[$];
  string ftag_q[$];
  string ptag_q[$];
  exp_t  pred = '0;
  exp_t  committed = '0;
  int    errors = 0;
  int    checks = 0;
  bit    watch_idle = 1'b0;
  bit    finished = 1'b0;

  task automatic chk(string tag, string what, logic [PC_W-1:0] act, logic [PC_W-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic cmp_state(string tag, exp_t e);
    chk(tag, "cwp", 64'(out_cwp), 64'(e.cwp));
    chk(tag, "pstate", 64'(out_pstate), 64'(e.pst));
    chk(tag, "asi", 64'(out_asi), 64'(e.asi));
    chk(tag, "pc", out_pc, e.pc);
    chk(tag, "npc", out_npc, e.npc);
    chk(tag, "tl", 64'(out_tl), 64'(e.tl));
  endtask

  // driver: predicts the result from the requirements and queues it
  task automatic send(input int fn, input bit ps, input bit hp, input int tl,
                      input logic [31:0] ts, input logic [PC_W-1:0] tpc,
                      input logic [PC_W-1:0] tnpc, input string ftag);
    exp_t nx;
    nx = pred;
    if (fn > 1)              nx.flt = 2'd1;   // R9
    else if (!(ps || hp))    nx.flt = 2'd2;   // R8
    else if (tl == 0)        nx.flt = 2'd1;   // R7
    else                     nx.flt = 2'd0;
    if (nx.flt == 2'd0) begin
      nx.cwp = ts[4:0];
      nx.pst = ts[20:8];
      nx.asi = ts[31:24];
      nx.pc  = (fn == 1) ? tpc : tnpc;
      nx.npc = (fn == 1) ? tnpc : tnpc + 64'd4;
      nx.tl  = TL_W'(tl - 1);
    end
    pred = nx;
    @(negedge clk);
    req_valid   = 1'b1;
    req_fn      = FCN_W'(fn);
    priv_state  = ps;
    priv_hyper  = hp;
    cur_tl      = TL_W'(tl);
    saved_state = ts;
    saved_pc    = tpc;
    saved_npc   = tnpc;
    exp_q.push_back(nx);
    ftag_q.push_back(ftag);
    ptag_q.push_back((fn == 1) ? "R5" : "R4");
  endtask

  // idle cycles with noise on the data inputs
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid   = 1'b0;
      req_fn      = FCN_W'(1);
      priv_state  = 1'b1;
      cur_tl      = TL_W'(5);
      saved_state = 32'hDEAD_BEEF ^ 32'(i);
      saved_pc    = 64'h1234_5678_9ABC_DEF0;
      saved_npc   = 64'h0FED_CBA9_8765_4321;
    end
  endtask

  // monitor: pops and compares as results appear
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (res_valid) begin
        if (exp_q.size() == 0) begin
          errors++; checks++;
          $display("FAIL R2 unexpected strobe actual=1 expected=0");
        end else begin
          exp_t e;
          string ft, pt;
          e  = exp_q.pop_front();
          ft = ftag_q.pop_front();
          pt = ptag_q.pop_front();
          chk(ft, "fault", 64'(res_fault), 64'(e.flt));
          chk("R3", "cwp", 64'(out_cwp), 64'(e.cwp));
          chk("R3", "pstate", 64'(out_pstate), 64'(e.pst));
          chk("R3", "asi", 64'(out_asi), 64'(e.asi));
          chk(pt, "pc", out_pc, e.pc);
          chk(pt, "npc", out_npc, e.npc);
          chk("R6", "tl", 64'(out_tl), 64'(e.tl));
          committed = e;
        end
      end else if (watch_idle) begin
        chk("R2", "no strobe", 64'(res_valid), 64'd0);
        cmp_state("R11", committed);
      end
    end
  end

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: cleared under reset
    chk("R1", "valid", 64'(res_valid), 64'd0);
    chk("R1", "fault", 64'(res_fault), 64'd0);
    cmp_state("R1", '0);
    @(negedge clk);
    rst = 1'b0;
    watch_idle = 1'b1;
    idle(2);

    // resume-after, processor-state privilege, R4 R6 R11
    send(0, 1, 0, 3, 32'hA5_1F3C_17, 64'h4000, 64'h4004, "R11");
    // re-execute back to back, R5
    send(1, 1, 0, 1, 32'h3C_0ABC_09, 64'h8000_0010, 64'h8000_0014, "R11");
    idle(2);
    // trap level zero, R7
    send(0, 1, 1, 0, 32'hFFFF_FFFF, 64'h1, 64'h2, "R7");
    idle(2);
    // no privilege and trap level zero: privileged action wins, R8
    send(1, 0, 0, 0, 32'h1111_1111, 64'h3, 64'h4, "R8");
    send(0, 0, 0, 5, 32'h2222_2222, 64'h5, 64'h6, "R8");
    idle(2);
    // hypervisor privilege alone, R10
    send(1, 0, 1, 7, 32'hFF_1FFF_1F, 64'hFFFF_0000_0000_0000, 64'hFFFF_0000_0000_0004, "R10");
    idle(1);
    // bad function codes, R9
    send(2, 1, 1, 4, 32'h7777_7777, 64'h9, 64'hA, "R9");
    send(31, 0, 0, 0, 32'h8888_8888, 64'hB, 64'hC, "R9");
    idle(2);
    // next-PC wraps at top of space, R4
    send(0, 0, 1, 2, 32'h00_0000_00, 64'h0, 64'hFFFF_FFFF_FFFF_FFFC, "R11");
    send(0, 1, 0, 1, 32'h5A_1234_0E, 64'h0, 64'hFFFF_FFFF_FFFF_FFFE, "R11");
    idle(4);

    if (exp_q.size() != 0) begin
      errors++; checks++;
      $display("FAIL R2 missing results actual=%0d expected=0", exp_q.size());
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule